// File: doc/BRIEF.md
# 32-bit Integer Execute Stage

This block is the arithmetic stage of a small in-order integer pipeline. Each cycle it can take one raw 32-bit instruction word together with the values already read for its two source registers and the address of that instruction. It decodes the instruction fields itself: the major opcode, the 3-bit operation field and the 7-bit modifier field, plus sign extension of the immediate. It then computes the result and presents it on registered outputs one clock later.

The stage covers these operations:

- arithmetic, comparison, bitwise and shift operations in both register-register and register-immediate forms;
- loading a 20-bit upper constant;
- adding a 20-bit upper constant to the instruction address.

Memory access, control flow, system operations and the register file are handled elsewhere. Any encoding outside this set is reported on an illegal flag, and no register write is requested for it.

Each output beat carries four things: a result word, a destination index, a write request and the illegal flag. A write is never requested for destination index 0, so the hardwired zero register stays zero.

Top module: `int_exec_unit`

## Requirements
- R1: Major opcode 0x33 (register-register) with modifier 0x00 and operation field 0 adds the operands. With modifier 0x20 and field 0 it subtracts the second operand from the first. Both wrap modulo 2^32.
- R2: Operation fields 4, 6 and 7 give XOR, OR and AND. In both forms these use the second register or the sign-extended 12-bit immediate in bits 31:20 (opcode 0x13).
- R3: The register-immediate add (opcode 0x13, field 0) adds the sign-extended 12-bit immediate to the first operand.
- R4: Register shifts use only bits 4:0 of the second operand. Field 1 is a left shift. Field 5 is a logical right shift with modifier 0x00 and an arithmetic right shift with modifier 0x20.
- R5: Immediate shifts take the amount from instruction bits 24:20. For field 5, bit 30 = 1 selects arithmetic and bit 30 = 0 selects logical.
- R6: Fields 2 and 3 are signed and unsigned less-than and produce exactly 1 or 0. The unsigned immediate compare treats the sign-extended immediate as an unsigned value.
- R7: Opcode 0x37 yields bits 31:12 of the instruction followed by twelve zeros. Opcode 0x17 yields that value plus the instruction address.
- R8: A destination index of 0 (bits 11:7) keeps the write request low for an otherwise legal instruction, and the illegal flag stays low.
- R9: The illegal flag is raised and the write request kept low in four cases:
  - any other major opcode;
  - opcode 0x33 with a modifier other than 0x00, or 0x20 paired with field 0 or 5;
  - an immediate left shift whose bits 31:25 are nonzero;
  - an immediate right shift with any of bits 31 and 29:25 set.
- R10: All outputs are registered. The output valid, write request and illegal flag appear in the cycle after the input valid and are low when the input valid was low. Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present this cycle |
| in_instr | input | 32 | Raw instruction word |
| in_src_a | input | 32 | Value of the first source register |
| in_src_b | input | 32 | Value of the second source register |
| in_pc | input | 32 | Address of the instruction |
| out_valid | output | 1 | Result beat present |
| out_result | output | 32 | Computed result (zero for an illegal instruction) |
| out_rd | output | 5 | Destination register index |
| out_we | output | 1 | Register write request |
| out_illegal | output | 1 | Unrecognised encoding |

## Verification
Faults inside the block show up on the beat after the instruction that exposes them, because the only state is the output register. A wrong decode of the modifier bit shows up as a sum where a difference was expected, or a logical shift where an arithmetic one was expected. A wrong sign-extension path corrupts the upper 20 bits of immediate results. A wrong legality term shows up as a write request paired with the illegal flag, or as a dropped write. The directed operand values are chosen so that each confusion gives a visibly different word.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_SLL  = 4'd2,
      ALU_SLT  = 4'd3,
      ALU_SLTU = 4'd4,
      ALU_XOR  = 4'd5,
      ALU_SRL  = 4'd6,
      ALU_SRA  = 4'd7,
      ALU_OR   = 4'd8,
      ALU_AND  = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      SRC_A_REG  = 2'd0,
      SRC_A_ZERO = 2'd1,
      SRC_A_PC   = 2'd2
   } src_a_e;

   localparam logic [6:0] OPC_REG_REG = 7'h33;
   localparam logic [6:0] OPC_REG_IMM = 7'h13;
   localparam logic [6:0] OPC_UPPER   = 7'h37;
   localparam logic [6:0] OPC_UPPER_PC = 7'h17;

   typedef struct packed {
      alu_op_e     op;
      src_a_e      a_sel;
      logic        b_is_imm;
      logic [31:0] imm;
      logic        legal;
   } dec_ctrl_t;

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
   import int_exec_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0] instr,
   output dec_ctrl_t   ctrl
);

   logic [6:0] opc;
   logic [2:0] fn3;
   logic [6:0] fn7;
   logic [XLEN-1:0] imm_i;
   logic [XLEN-1:0] imm_u;
   logic unused_fields;

   assign opc   = instr[6:0];
   assign fn3   = instr[14:12];
   assign fn7   = instr[31:25];
   assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
   assign imm_u = {instr[31:12], 12'b0};
   assign unused_fields = ^instr[19:15];

   function automatic alu_op_e base_op(input logic [2:0] f);
      case (f)
         3'd0:    base_op = ALU_ADD;
         3'd1:    base_op = ALU_SLL;
         3'd2:    base_op = ALU_SLT;
         3'd3:    base_op = ALU_SLTU;
         3'd4:    base_op = ALU_XOR;
         3'd5:    base_op = ALU_SRL;
         3'd6:    base_op = ALU_OR;
         default: base_op = ALU_AND;
      endcase
   endfunction

   always_comb begin
      ctrl.op       = base_op(fn3);
      ctrl.a_sel    = SRC_A_REG;
      ctrl.b_is_imm = 1'b0;
      ctrl.imm      = imm_i;
      ctrl.legal    = 1'b0;
      case (opc)
         OPC_REG_REG: begin
            if (fn7 == 7'h00) begin
               ctrl.legal = 1'b1;
            end else if (fn7 == 7'h20 && fn3 == 3'd0) begin
               ctrl.legal = 1'b1;
               ctrl.op    = ALU_SUB;
            end else if (fn7 == 7'h20 && fn3 == 3'd5) begin
               ctrl.legal = 1'b1;
               ctrl.op    = ALU_SRA;
            end
         end
         OPC_REG_IMM: begin
            ctrl.b_is_imm = 1'b1;
            if (fn3 == 3'd1) begin
               ctrl.legal = (fn7 == 7'h00);
            end else if (fn3 == 3'd5) begin
               ctrl.legal = ({fn7[6], fn7[4:0]} == 6'd0);
               ctrl.op    = fn7[5] ? ALU_SRA : ALU_SRL;
            end else begin
               ctrl.legal = 1'b1;
            end
         end
         OPC_UPPER: begin
            ctrl.legal    = 1'b1;
            ctrl.op       = ALU_ADD;
            ctrl.a_sel    = SRC_A_ZERO;
            ctrl.b_is_imm = 1'b1;
            ctrl.imm      = imm_u;
         end
         OPC_UPPER_PC: begin
            ctrl.legal    = 1'b1;
            ctrl.op       = ALU_ADD;
            ctrl.a_sel    = SRC_A_PC;
            ctrl.b_is_imm = 1'b1;
            ctrl.imm      = imm_u;
         end
         default: ctrl.legal = 1'b0;
      endcase
   end

   // R9: an upper-immediate form must always decode as legal
   always_comb begin
      if (opc == OPC_UPPER || opc == OPC_UPPER_PC)
         assert_upper_legal_R9: assert (ctrl.legal);
   end

endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
   import int_exec_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit STAGED_SHIFT = 1'b1,
   localparam int SHW = $clog2(XLEN)
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [SHW-1:0]  shamt,
   output logic [XLEN-1:0] res
);

   logic [XLEN-1:0] shl;
   logic [XLEN-1:0] shr;
   logic            fill;

   assign fill = (op == ALU_SRA) & a[XLEN-1];

   generate
      if (STAGED_SHIFT) begin : g_staged
         logic [XLEN-1:0] lstage [SHW+1];
         logic [XLEN-1:0] rstage [SHW+1];
         assign lstage[0] = a;
         assign rstage[0] = a;
         for (genvar s = 0; s < SHW; s++) begin : g_stage
            localparam int DIST = 1 << s;
            assign lstage[s+1] = shamt[s] ? {lstage[s][XLEN-1-DIST:0], {DIST{1'b0}}} : lstage[s];
            assign rstage[s+1] = shamt[s] ? {{DIST{fill}}, rstage[s][XLEN-1:DIST]} : rstage[s];
         end
         assign shl = lstage[SHW];
         assign shr = rstage[SHW];
      end else begin : g_operator
         logic signed [XLEN:0] ext;
         logic [XLEN:0]        ext_sh;
         logic                 unused_top;
         assign ext        = {fill, a};
         assign ext_sh     = ext >>> shamt;
         assign shr        = ext_sh[XLEN-1:0];
         assign unused_top = ext_sh[XLEN];
         assign shl        = a << shamt;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_ADD:  res = a + b;
         ALU_SUB:  res = a - b;
         ALU_SLL:  res = shl;
         ALU_SLT:  res = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
         ALU_SLTU: res = {{(XLEN-1){1'b0}}, a < b};
         ALU_XOR:  res = a ^ b;
         ALU_SRL:  res = shr;
         ALU_SRA:  res = shr;
         ALU_OR:   res = a | b;
         ALU_AND:  res = a & b;
         default:  res = '0;
      endcase
   end

   // R4: a zero shift amount returns the operand unchanged
   always_comb begin
      if ((op == ALU_SLL || op == ALU_SRL || op == ALU_SRA) && shamt == '0)
         assert_shift_zero_identity_R4: assert (res == a);
   end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import int_exec_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int REG_COUNT    = 32,
   parameter bit STAGED_SHIFT = 1'b1,
   localparam int RDW = $clog2(REG_COUNT),
   localparam int SHW = $clog2(XLEN)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [31:0]     in_instr,
   input  logic [XLEN-1:0] in_src_a,
   input  logic [XLEN-1:0] in_src_b,
   input  logic [XLEN-1:0] in_pc,
   output logic            out_valid,
   output logic [XLEN-1:0] out_result,
   output logic [RDW-1:0]  out_rd,
   output logic            out_we,
   output logic            out_illegal
);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("int_exec_unit supports only a 32-bit datapath");
      end
      if (RDW != 5) begin : g_bad_regs
         $error("int_exec_unit needs a 5-bit destination field");
      end
   endgenerate

   dec_ctrl_t       ctrl;
   logic [XLEN-1:0] opnd_a;
   logic [XLEN-1:0] opnd_b;
   logic [SHW-1:0]  shamt;
   logic [XLEN-1:0] alu_res;
   logic [RDW-1:0]  rd_idx;

   int_exec_decode #(.XLEN(XLEN)) u_decode (
      .instr (in_instr),
      .ctrl  (ctrl)
   );

   always_comb begin
      case (ctrl.a_sel)
         SRC_A_ZERO: opnd_a = '0;
         SRC_A_PC:   opnd_a = in_pc;
         default:    opnd_a = in_src_a;
      endcase
   end

   assign opnd_b = ctrl.b_is_imm ? ctrl.imm : in_src_b;
   assign shamt  = opnd_b[SHW-1:0];
   assign rd_idx = in_instr[11:7];

   int_exec_alu #(.XLEN(XLEN), .STAGED_SHIFT(STAGED_SHIFT)) u_alu (
      .op    (ctrl.op),
      .a     (opnd_a),
      .b     (opnd_b),
      .shamt (shamt),
      .res   (alu_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_rd      <= '0;
         out_we      <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         out_we      <= in_valid & ctrl.legal & (rd_idx != '0);
         out_illegal <= in_valid & ~ctrl.legal;
         if (in_valid) begin
            out_result <= ctrl.legal ? alu_res : '0;
            out_rd     <= rd_idx;
         end
      end
   end

   // R8: no write to the zero register
   assert_no_zero_write_R8: assert property (@(posedge clk) disable iff (rst)
      out_we |-> out_rd != '0);

   // R9: illegal beats never write and always travel with a valid beat
   assert_illegal_blocks_write_R9: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (!out_we && out_valid));

   // R10: output valid follows input valid by one cycle
   assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R10: no beat and no write without an input
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_we && !out_illegal));

endmodule

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [31:0] in_instr;
   logic [31:0] in_src_a;
   logic [31:0] in_src_b;
   logic [31:0] in_pc;
   logic        out_valid;
   logic [31:0] out_result;
   logic [4:0]  out_rd;
   logic        out_we;
   logic        out_illegal;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   int_exec_unit u_int_exec_unit (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_instr    (in_instr),
      .in_src_a    (in_src_a),
      .in_src_b    (in_src_b),
      .in_pc       (in_pc),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_rd      (out_rd),
      .out_we      (out_we),
      .out_illegal (out_illegal)
   );

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [2:0] f3, input logic [4:0] rd);
      return {f7, 5'd2, 5'd1, f3, rd, 7'h33};
   endfunction

   function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f3, input logic [4:0] rd);
      return {imm, 5'd1, f3, rd, 7'h13};
   endfunction

   function automatic logic [31:0] enc_u(input logic [19:0] imm, input logic [6:0] opc, input logic [4:0] rd);
      return {imm, rd, opc};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one instruction, then sample the registered beat at the next falling edge
   task automatic issue(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input logic [31:0] pc);
      @(negedge clk);
      in_valid = 1'b1;
      in_instr = ins;
      in_src_a = a;
      in_src_b = b;
      in_pc    = pc;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_write(input string req, input logic [31:0] exp_res, input logic [4:0] rd);
      check({req, " valid"}, {31'b0, out_valid}, 32'd1);
      check({req, " result"}, out_result, exp_res);
      check({req, " rd"}, {27'b0, out_rd}, {27'b0, rd});
      check({req, " we"}, {31'b0, out_we}, 32'd1);
      check({req, " illegal"}, {31'b0, out_illegal}, 32'd0);
   endtask

   task automatic expect_illegal(input string req);
      check({req, " valid"}, {31'b0, out_valid}, 32'd1);
      check({req, " we"}, {31'b0, out_we}, 32'd0);
      check({req, " illegal"}, {31'b0, out_illegal}, 32'd1);
   endtask

   task automatic t_reset_state;
      check("R10 reset valid", {31'b0, out_valid}, 32'd0);
      check("R10 reset result", out_result, 32'd0);
      check("R10 reset we", {31'b0, out_we}, 32'd0);
      check("R10 reset illegal", {31'b0, out_illegal}, 32'd0);
   endtask

   task automatic t_add_sub;
      issue(enc_r(7'h00, 3'd0, 5'd3), 32'd5, 32'd7, 32'd0);
      expect_write("R1 add", 32'd12, 5'd3);
      issue(enc_r(7'h20, 3'd0, 5'd4), 32'd5, 32'd7, 32'd0);
      expect_write("R1 sub", 32'hFFFF_FFFE, 5'd4);
      issue(enc_r(7'h00, 3'd0, 5'd5), 32'hFFFF_FFFF, 32'd2, 32'd0);
      expect_write("R1 add wrap", 32'd1, 5'd5);
   endtask

   task automatic t_logic;
      issue(enc_r(7'h00, 3'd4, 5'd6), 32'hF0F0_F0F0, 32'hFF00_FF00, 32'd0);
      expect_write("R2 xor", 32'h0FF0_0FF0, 5'd6);
      issue(enc_r(7'h00, 3'd6, 5'd6), 32'hF0F0_0000, 32'h0000_0F0F, 32'd0);
      expect_write("R2 or", 32'hF0F0_0F0F, 5'd6);
      issue(enc_i(12'h800, 3'd7, 5'd7), 32'h1234_5FFF, 32'd0, 32'd0);
      expect_write("R2 andi sext", 32'h1234_5800, 5'd7);
      issue(enc_i(12'hFFF, 3'd4, 5'd7), 32'h0000_00FF, 32'd0, 32'd0);
      expect_write("R2 xori sext", 32'hFFFF_FF00, 5'd7);
   endtask

   task automatic t_addi;
      issue(enc_i(12'hFFF, 3'd0, 5'd8), 32'd10, 32'hDEAD_BEEF, 32'd0);
      expect_write("R3 addi neg", 32'd9, 5'd8);
      issue(enc_i(12'h7FF, 3'd0, 5'd8), 32'd1, 32'd0, 32'd0);
      expect_write("R3 addi pos", 32'd2048, 5'd8);
   endtask

   task automatic t_reg_shift;
      issue(enc_r(7'h00, 3'd1, 5'd9), 32'h0000_0003, 32'hFFFF_FFE1, 32'd0);
      expect_write("R4 sll low bits", 32'h0000_0006, 5'd9);
      issue(enc_r(7'h00, 3'd5, 5'd9), 32'h8000_0000, 32'd4, 32'd0);
      expect_write("R4 srl", 32'h0800_0000, 5'd9);
      issue(enc_r(7'h20, 3'd5, 5'd9), 32'h8000_0000, 32'd36, 32'd0);
      expect_write("R4 sra", 32'hF800_0000, 5'd9);
   endtask

   task automatic t_imm_shift;
      issue(enc_i({7'h00, 5'd31}, 3'd1, 5'd10), 32'd1, 32'd0, 32'd0);
      expect_write("R5 slli", 32'h8000_0000, 5'd10);
      issue(enc_i({7'h00, 5'd8}, 3'd5, 5'd10), 32'h8765_4321, 32'd0, 32'd0);
      expect_write("R5 srli", 32'h0087_6543, 5'd10);
      issue(enc_i({7'h20, 5'd8}, 3'd5, 5'd10), 32'h8765_4321, 32'd0, 32'd0);
      expect_write("R5 srai", 32'hFF87_6543, 5'd10);
   endtask

   task automatic t_compare;
      issue(enc_r(7'h00, 3'd2, 5'd11), 32'hFFFF_FFFF, 32'd1, 32'd0);
      expect_write("R6 slt", 32'd1, 5'd11);
      issue(enc_r(7'h00, 3'd3, 5'd11), 32'hFFFF_FFFF, 32'd1, 32'd0);
      expect_write("R6 sltu", 32'd0, 5'd11);
      issue(enc_i(12'hFFF, 3'd3, 5'd11), 32'd5, 32'd0, 32'd0);
      expect_write("R6 sltiu sext", 32'd1, 5'd11);
      issue(enc_i(12'hFFF, 3'd2, 5'd11), 32'd5, 32'd0, 32'd0);
      expect_write("R6 slti", 32'd0, 5'd11);
   endtask

   task automatic t_upper;
      issue(enc_u(20'hABCDE, 7'h37, 5'd12), 32'h1111_1111, 32'h2222_2222, 32'h0000_4000);
      expect_write("R7 upper", 32'hABCD_E000, 5'd12);
      issue(enc_u(20'h00001, 7'h17, 5'd12), 32'h1111_1111, 32'd0, 32'h0000_4004);
      expect_write("R7 upper pc", 32'h0000_5004, 5'd12);
   endtask

   task automatic t_rd_zero;
      issue(enc_r(7'h00, 3'd0, 5'd0), 32'd1, 32'd1, 32'd0);
      check("R8 valid", {31'b0, out_valid}, 32'd1);
      check("R8 we", {31'b0, out_we}, 32'd0);
      check("R8 illegal", {31'b0, out_illegal}, 32'd0);
   endtask

   task automatic t_illegal;
      issue({25'd0, 7'h03}, 32'd1, 32'd1, 32'd0);
      expect_illegal("R9 opcode");
      issue(enc_r(7'h20, 3'd1, 5'd13), 32'd1, 32'd1, 32'd0);
      expect_illegal("R9 modifier on sll");
      issue(enc_r(7'h01, 3'd0, 5'd13), 32'd1, 32'd1, 32'd0);
      expect_illegal("R9 modifier 01");
      issue(enc_i({7'h20, 5'd1}, 3'd1, 5'd13), 32'd1, 32'd0, 32'd0);
      expect_illegal("R9 slli bit30");
      issue(enc_i({7'h21, 5'd1}, 3'd5, 5'd13), 32'd1, 32'd0, 32'd0);
      expect_illegal("R9 srai bit25");
   endtask

   task automatic t_idle;
      @(negedge clk);
      check("R10 idle valid", {31'b0, out_valid}, 32'd0);
      check("R10 idle we", {31'b0, out_we}, 32'd0);
      check("R10 idle illegal", {31'b0, out_illegal}, 32'd0);
   endtask

   initial begin
      rst      = 1'b1;
      in_valid = 1'b0;
      in_instr = '0;
      in_src_a = '0;
      in_src_b = '0;
      in_pc    = '0;
      repeat (3) @(negedge clk);
      t_reset_state();
      rst = 1'b0;
      t_add_sub();
      t_logic();
      t_addi();
      t_reg_shift();
      t_imm_shift();
      t_compare();
      t_upper();
      t_rd_zero();
      t_illegal();
      t_idle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule